// File: doc/BRIEF.md
# Wiper Position Register with Step Mode

This block keeps the tap position of each potentiometer in a multi-pot digital resistor, one PW-bit code per pot (6 bits by default, 64 taps), and turns every code into a one-hot switch-enable vector for the analog array. Code 0 is the tap at the low terminal and the all-ones code is the tap at the high terminal. The serial bus controller next to this block decodes the protocol and hands over qualified strobes. These are a host write of a new position, a parallel load from stored data registers, a power-up recall of each pot's register zero, and the signals that drive step mode.

Step mode starts when the controller reports that the up/down instruction for a chosen pot has been acknowledged (`step_start`). From then on, each sampled rising edge of the bus clock (`scl_rise`) moves that pot's wiper by one tap. The sampled data line level (`sda_smp`) sets the direction: 1 moves toward the high terminal, 0 toward the low terminal. A stop condition (`stop_det`) ends step mode. A small state machine controls step mode. It has two states, ST_IDLE and ST_STEP, and these transitions: T_ENTER (ST_IDLE to ST_STEP on `step_start`), T_EXIT (ST_STEP to ST_IDLE on `stop_det` or `recall_req`) and T_STAY (every other case, the state is held). The position registers are volatile and return to code 0 on reset until a recall is requested.

Top module: `wiper_posreg_top`

## Requirements
- R1: For pot p, bit p*64+k of `tap_sel` is 1 if and only if the position of pot p equals k. Exactly one bit per pot is set, so position 0 selects bit p*64 (low terminal) and position 63 selects bit p*64+63 (high terminal).
- R2: `recall_req` loads every pot from its slice of `recall_pos` (pot p in bits p*6+5..p*6) on the next clock. It overrides every other source and ends step mode.
- R3: `wr_stb` loads `wr_pos` into the pot numbered `wr_pot` on the next clock. Other pots are unchanged. If the same pot is also targeted by a transfer in that cycle, the write wins.
- R4: `xfr_stb` loads each pot whose `xfr_mask` bit is set from its slice of `xfr_pos` on the next clock. Pots whose mask bit is clear keep their position.
- R5: `step_start` in ST_IDLE enters ST_STEP for pot `step_pot`, and `step_active` reads 1 from the next clock. A `step_start` while already in ST_STEP is ignored: the stepped pot does not change.
- R6: In ST_STEP, `scl_rise` with `sda_smp`=1 adds one to the selected pot's position and with `sda_smp`=0 subtracts one, on the next clock. All other pots are unchanged.
- R7: Stepping saturates: an up step at 63 leaves 63 and a down step at 0 leaves 0.
- R8: `stop_det` in ST_STEP returns to ST_IDLE on the next clock, and an `scl_rise` in that same cycle does not step. An `scl_rise` in ST_IDLE has no effect on any position.
- R9: After reset, every position is 0 and `step_active` is 0.
- R10: A write or transfer to the stepped pot in the same cycle as a step takes the loaded value, and the step is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| recall_req | input | 1 | Power-up recall strobe for all pots |
| recall_pos | input | 12 | Stored register-zero value of each pot |
| wr_stb | input | 1 | Host write strobe |
| wr_pot | input | 1 | Pot number for the host write |
| wr_pos | input | 6 | Host write value |
| xfr_stb | input | 1 | Parallel load strobe |
| xfr_mask | input | 2 | Pots affected by the parallel load |
| xfr_pos | input | 12 | Parallel load values, one slice per pot |
| step_start | input | 1 | Up/down instruction acknowledged |
| step_pot | input | 1 | Pot addressed by the up/down instruction |
| stop_det | input | 1 | Stop condition seen on the bus |
| scl_rise | input | 1 | Sampled rising edge of the bus clock |
| sda_smp | input | 1 | Data line level sampled on that edge |
| pos_out | output | 12 | Current position of every pot |
| tap_sel | output | 128 | One-hot switch enables, 64 per pot |
| step_active | output | 1 | Step mode is active |

## Verification
The hardest cases to reach from the ports are collisions in a single cycle: a stop arriving together with a bus clock edge, a second up/down instruction while stepping, and a load to the stepped pot arriving together with a step. The stimulus first drives a pot to one code below the top or one code above the bottom by a host write while step mode stays active. It then issues runs of steps that cross the limit, and places these collisions in the same cycle on purpose. A recall issued during step mode checks that recall wins over everything and leaves step mode.

// File: rtl/wpr_pkg.sv
package wpr_pkg;

    // step-mode control states
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_STEP = 1'b1
    } step_state_e;

    // source that updates a position register in a given cycle
    typedef enum logic [1:0] {
        SRC_HOLD   = 2'd0,
        SRC_RECALL = 2'd1,
        SRC_LOAD   = 2'd2,
        SRC_STEP   = 2'd3
    } pos_src_e;

endpackage

// File: rtl/wiper_step_fsm.sv
module wiper_step_fsm
    import wpr_pkg::*;
#(
    parameter int NPOT = 2,
    parameter int SELW = 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            recall_req,
    input  logic            step_start,
    input  logic [SELW-1:0] step_pot,
    input  logic            stop_det,
    input  logic            scl_rise,
    input  logic            sda_smp,
    output logic            step_active,
    output logic [NPOT-1:0] step_hit,
    output logic            step_up
);

    step_state_e     state_q, state_d;
    logic [SELW-1:0] pot_q, pot_d;
    logic            edge_ok;

    // next-state logic
    always_comb begin
        state_d = state_q;
        pot_d   = pot_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!recall_req && step_start) begin
                    state_d = ST_STEP;      // T_ENTER
                    pot_d   = step_pot;
                end
            end
            ST_STEP: begin
                if (recall_req || stop_det) begin
                    state_d = ST_IDLE;      // T_EXIT
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            pot_q   <= '0;
        end else begin
            state_q <= state_d;
            pot_q   <= pot_d;
        end
    end

    // outputs
    always_comb begin
        step_active = 1'b0;
        edge_ok     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                step_active = 1'b0;
                edge_ok     = 1'b0;
            end
            ST_STEP: begin
                step_active = 1'b1;
                edge_ok     = scl_rise && !stop_det && !recall_req;
            end
            default: begin
                step_active = 1'b0;
                edge_ok     = 1'b0;
            end
        endcase
        step_up = sda_smp;
    end

    for (genvar p = 0; p < NPOT; p++) begin : g_hit
        assign step_hit[p] = edge_ok && (pot_q == SELW'(p));
    end

    AST_STOP_LEAVES_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && stop_det) |=> (state_q == ST_IDLE)); // R8

    AST_STEP_POT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP && !stop_det && !recall_req)
            |=> (state_q == ST_STEP && $stable(pot_q))); // R5

    AST_ONE_POT_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_hit)); // R6

    AST_IDLE_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (step_hit == '0)); // R8

endmodule

// File: rtl/wiper_pos_reg.sv
module wiper_pos_reg
    import wpr_pkg::*;
#(
    parameter int PW = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          recall_stb,
    input  logic [PW-1:0] recall_val,
    input  logic          load_stb,
    input  logic [PW-1:0] load_val,
    input  logic          step_hit,
    input  logic          step_up,
    output logic [PW-1:0] pos
);

    localparam logic [PW-1:0] POS_MAX = '1;
    localparam logic [PW-1:0] POS_MIN = '0;

    pos_src_e      src;
    logic [PW-1:0] pos_d;
    logic [PW-1:0] stepped;

    // priority: recall, then load, then step
    always_comb begin
        if (recall_stb)      src = SRC_RECALL;
        else if (load_stb)   src = SRC_LOAD;
        else if (step_hit)   src = SRC_STEP;
        else                 src = SRC_HOLD;
    end

    always_comb begin
        if (step_up) stepped = (pos == POS_MAX) ? pos : pos + 1'b1;
        else         stepped = (pos == POS_MIN) ? pos : pos - 1'b1;
    end

    always_comb begin
        unique case (src)
            SRC_RECALL: pos_d = recall_val;
            SRC_LOAD:   pos_d = load_val;
            SRC_STEP:   pos_d = stepped;
            SRC_HOLD:   pos_d = pos;
            default:    pos_d = pos;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pos <= '0;
        else        pos <= pos_d;
    end

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (load_stb && !recall_stb) |=> (pos == $past(load_val))); // R10

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hit && step_up && !load_stb && !recall_stb && pos == POS_MAX)
            |=> (pos == POS_MAX)); // R7

    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hit && !step_up && !load_stb && !recall_stb && pos == POS_MIN)
            |=> (pos == POS_MIN)); // R7

    AST_STEP_UP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hit && step_up && !load_stb && !recall_stb && pos != POS_MAX)
            |=> (pos == $past(pos) + 1'b1)); // R6

    AST_STEP_DN_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (step_hit && !step_up && !load_stb && !recall_stb && pos != POS_MIN)
            |=> (pos == $past(pos) - 1'b1)); // R6

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_hit && !load_stb && !recall_stb) |=> $stable(pos)); // R8

endmodule

// File: rtl/wiper_tap_decode.sv
module wiper_tap_decode #(
    parameter int PW   = 6,
    parameter int TAPS = 1 << PW
) (
    input  logic [PW-1:0]   pos,
    output logic [TAPS-1:0] taps
);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        assign taps[k] = (pos == PW'(k));
    end

endmodule

// File: rtl/wiper_posreg_top.sv
module wiper_posreg_top
    import wpr_pkg::*;
#(
    parameter int NPOT = 2,
    parameter int PW   = 6,
    localparam int TAPS = 1 << PW,
    localparam int SELW = (NPOT > 1) ? $clog2(NPOT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 recall_req,
    input  logic [NPOT*PW-1:0]   recall_pos,
    input  logic                 wr_stb,
    input  logic [SELW-1:0]      wr_pot,
    input  logic [PW-1:0]        wr_pos,
    input  logic                 xfr_stb,
    input  logic [NPOT-1:0]      xfr_mask,
    input  logic [NPOT*PW-1:0]   xfr_pos,
    input  logic                 step_start,
    input  logic [SELW-1:0]      step_pot,
    input  logic                 stop_det,
    input  logic                 scl_rise,
    input  logic                 sda_smp,
    output logic [NPOT*PW-1:0]   pos_out,
    output logic [NPOT*TAPS-1:0] tap_sel,
    output logic                 step_active
);

    logic [NPOT-1:0] step_hit;
    logic            step_up;

    wiper_step_fsm #(.NPOT(NPOT), .SELW(SELW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .recall_req (recall_req),
        .step_start (step_start),
        .step_pot   (step_pot),
        .stop_det   (stop_det),
        .scl_rise   (scl_rise),
        .sda_smp    (sda_smp),
        .step_active(step_active),
        .step_hit   (step_hit),
        .step_up    (step_up)
    );

    for (genvar p = 0; p < NPOT; p++) begin : g_pot
        logic          wr_hit, xfr_hit, load_stb;
        logic [PW-1:0] load_val;

        assign wr_hit   = wr_stb && (wr_pot == SELW'(p));
        assign xfr_hit  = xfr_stb && xfr_mask[p];
        assign load_stb = wr_hit || xfr_hit;
        assign load_val = wr_hit ? wr_pos : xfr_pos[p*PW +: PW];

        wiper_pos_reg #(.PW(PW)) u_reg (
            .clk       (clk),
            .rst_n     (rst_n),
            .recall_stb(recall_req),
            .recall_val(recall_pos[p*PW +: PW]),
            .load_stb  (load_stb),
            .load_val  (load_val),
            .step_hit  (step_hit[p]),
            .step_up   (step_up),
            .pos       (pos_out[p*PW +: PW])
        );

        wiper_tap_decode #(.PW(PW), .TAPS(TAPS)) u_dec (
            .pos (pos_out[p*PW +: PW]),
            .taps(tap_sel[p*TAPS +: TAPS])
        );

        AST_ONE_TAP_ON: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(tap_sel[p*TAPS +: TAPS]) == 1); // R1

        AST_WRITE_OVER_XFR: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_hit && xfr_hit && !recall_req) |=> (pos_out[p*PW +: PW] == $past(wr_pos))); // R3
    end

    AST_RECALL_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> (pos_out == $past(recall_pos) && !step_active)); // R2

    AST_ENTER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_active && step_start && !recall_req) |=> step_active); // R5

endmodule

// File: tb/wiper_posreg_top_tb_top.sv
module wiper_posreg_top_tb_top;

    localparam int NPOT = 2;
    localparam int PW   = 6;
    localparam int TAPS = 64;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 recall_req = 1'b0;
    logic [NPOT*PW-1:0]   recall_pos = '0;
    logic                 wr_stb = 1'b0;
    logic [0:0]           wr_pot = '0;
    logic [PW-1:0]        wr_pos = '0;
    logic                 xfr_stb = 1'b0;
    logic [NPOT-1:0]      xfr_mask = '0;
    logic [NPOT*PW-1:0]   xfr_pos = '0;
    logic                 step_start = 1'b0;
    logic [0:0]           step_pot = '0;
    logic                 stop_det = 1'b0;
    logic                 scl_rise = 1'b0;
    logic                 sda_smp = 1'b0;
    logic [NPOT*PW-1:0]   pos_out;
    logic [NPOT*TAPS-1:0] tap_sel;
    logic                 step_active;

    always #2 clk = ~clk;

    wiper_posreg_top dut_i (
        .clk(clk), .rst_n(rst_n),
        .recall_req(recall_req), .recall_pos(recall_pos),
        .wr_stb(wr_stb), .wr_pot(wr_pot), .wr_pos(wr_pos),
        .xfr_stb(xfr_stb), .xfr_mask(xfr_mask), .xfr_pos(xfr_pos),
        .step_start(step_start), .step_pot(step_pot),
        .stop_det(stop_det), .scl_rise(scl_rise), .sda_smp(sda_smp),
        .pos_out(pos_out), .tap_sel(tap_sel), .step_active(step_active)
    );

    typedef struct {
        logic [NPOT*PW-1:0]   pos;
        logic [NPOT*TAPS-1:0] tap;
        logic                 act;
        string                tag;
    } exp_t;

    exp_t q[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    // reference model state
    logic [PW-1:0] m_pos [NPOT];
    logic          m_act;
    logic          m_pot;

    function automatic exp_t make_exp(string tag);
        exp_t e;
        e.tag = tag;
        e.act = m_act;
        e.tap = '0;
        for (int p = 0; p < NPOT; p++) begin
            e.pos[p*PW +: PW] = m_pos[p];
            e.tap[p*TAPS + int'(m_pos[p])] = 1'b1;
        end
        return e;
    endfunction

    // driver: one cycle of stimulus, model update, expected item pushed
    task automatic drive(input logic rc, input logic [11:0] rv,
                         input logic w, input logic wp, input logic [5:0] wv,
                         input logic x, input logic [1:0] xm, input logic [11:0] xv,
                         input logic st, input logic sp, input logic stp,
                         input logic sc, input logic sd, input string tag);
        logic [PW-1:0] np [NPOT];
        logic na, npot;
        @(negedge clk);
        recall_req = rc; recall_pos = rv; wr_stb = w; wr_pot = wp; wr_pos = wv;
        xfr_stb = x; xfr_mask = xm; xfr_pos = xv; step_start = st; step_pot = sp;
        stop_det = stp; scl_rise = sc; sda_smp = sd;
        for (int p = 0; p < NPOT; p++) begin
            np[p] = m_pos[p];
            if (rc) np[p] = rv[p*PW +: PW];
            else if (w && wp == p[0]) np[p] = wv;
            else if (x && xm[p]) np[p] = xv[p*PW +: PW];
            else if (m_act && sc && !stp && m_pot == p[0]) begin
                if (sd) np[p] = (m_pos[p] == 6'd63) ? 6'd63 : m_pos[p] + 6'd1;
                else    np[p] = (m_pos[p] == 6'd0)  ? 6'd0  : m_pos[p] - 6'd1;
            end
        end
        na = m_act; npot = m_pot;
        if (rc) na = 1'b0;
        else if (m_act) na = !stp;
        else if (st) begin na = 1'b1; npot = sp; end
        @(posedge clk);
        #1;
        for (int p = 0; p < NPOT; p++) m_pos[p] = np[p];
        m_act = na; m_pot = npot;
        q.push_back(make_exp(tag));
        recall_req = 1'b0; wr_stb = 1'b0; xfr_stb = 1'b0; step_start = 1'b0;
        stop_det = 1'b0; scl_rise = 1'b0;
    endtask

    task automatic idle(input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    task automatic step(input logic dir, input string tag);
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, dir, tag);
    endtask

    task automatic write(input logic wp, input logic [5:0] wv, input string tag);
        drive(0, 0, 1, wp, wv, 0, 0, 0, 0, 0, 0, 0, 0, tag);
    endtask

    // monitor: compare against the scoreboard away from the active edge
    always @(negedge clk) begin
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_cmp++;
            if (pos_out !== e.pos || tap_sel !== e.tap || step_active !== e.act) begin
                n_bad++;
                $display("FAIL %s: pos=%h tap=%h act=%b expected pos=%h tap=%h act=%b",
                         e.tag, pos_out, tap_sel, step_active, e.pos, e.tap, e.act);
            end
        end
    end

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NPOT; p++) m_pos[p] = '0;
        m_act = 1'b0; m_pot = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        idle("R9 reset state");
        // R2 recall: pot0=5, pot1=40
        drive(1, {6'd40, 6'd5}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R2 recall");
        idle("R8 scl in idle ignored");
        step(1, "R8 scl in idle ignored");
        // R3 host writes, R1 ends of decode
        write(1, 6'd63, "R3 write pot1 top / R1");
        write(0, 6'd0, "R3 write pot0 bottom / R1");
        // R4 transfers
        drive(0, 0, 0, 0, 0, 1, 2'b11, {6'd20, 6'd10}, 0, 0, 0, 0, 0, "R4 global transfer");
        drive(0, 0, 0, 0, 0, 1, 2'b01, {6'd50, 6'd33}, 0, 0, 0, 0, 0, "R4 masked transfer");
        // R3 write beats transfer to same pot
        drive(0, 0, 1, 1, 6'd7, 1, 2'b11, {6'd9, 6'd8}, 0, 0, 0, 0, 0, "R3 write over transfer");
        // R5 enter step mode on pot0
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0, "R5 enter step");
        step(1, "R6 step up");
        step(1, "R6 step up");
        step(0, "R6 step down");
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 1, 1, "R5 restart ignored");
        step(1, "R5 still pot0");
        // R7 saturation at top
        write(0, 6'd62, "R7 preset 62");
        for (int i = 0; i < 3; i++) step(1, "R7 saturate top");
        write(0, 6'd1, "R7 preset 1");
        for (int i = 0; i < 3; i++) step(0, "R7 saturate bottom");
        // R10 load and step together on pot0
        drive(0, 0, 1, 0, 6'd30, 0, 0, 0, 0, 0, 0, 1, 1, "R10 write beats step");
        drive(0, 0, 0, 0, 0, 1, 2'b01, {6'd0, 6'd12}, 0, 0, 0, 1, 0, "R10 transfer beats step");
        // R8 stop together with scl
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, "R8 stop with scl");
        step(1, "R8 no step after stop");
        // step pot1, then recall during step mode
        drive(0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 0, 0, 0, "R5 enter step pot1");
        step(0, "R6 pot1 down");
        step(1, "R6 pot1 up");
        step(1, "R6 pot1 up");
        drive(1, {6'd3, 6'd60}, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, "R2 recall ends step");
        step(1, "R2 idle after recall");
        idle("R1 final");
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule